// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block decides which interrupt an 8-bit CPU services next, and when. Each maskable source has a two-bit software level, set through a small write-only register port. The CPU reports its current two-bit mask. At an instruction boundary, the block takes the eligible source with the highest software level. The outputs are a one-cycle take pulse, the two-byte vector address to fetch, and the new mask value the CPU must load. Three events ignore the mask: a reset request, a TRAP strobe and a top-level interrupt (TLI) line.

Every take except a reset stores the CPU's mask of that moment on a small internal stack. An IRET strobe pops the stack and hands the stored mask back to the CPU, so nested handlers unwind level by level. A stack that is too full or too empty is reported by a one-cycle error pulse. The CPU datapath, saving registers to memory and clearing peripheral flags are handled elsewhere.

Top module: `nest_irq_ctrl`

## Requirements
- R1: The mask encodes four levels: 2'b10 is level 0, 2'b01 is level 1, 2'b00 is level 2 and 2'b11 is level 3. A maskable source is taken only if its level is strictly above the current level. Otherwise its request stays pending and is taken at a later boundary once the mask has dropped.
- R2: Priority register r (reg_addr = r) holds source 4r+j in bits [2j+1:2j] of reg_wdata, using the R1 encoding. Every field resets to 2'b11. A source whose field is 2'b11 is never taken.
- R3: A maskable source or TLI is taken only when instr_end is high at the deciding clock edge. The outputs appear in the cycle after that edge.
- R4: Taking maskable source i drives irq_vec = 16'hFFE0 + 2*i. It pulses mask_load with mask_new equal to that source's field.
- R5: Among eligible sources, the highest software level wins. Between equal levels, the higher source index wins.
- R6: TLI is a level input. When it is high at an instruction boundary it is taken regardless of the mask. It beats every maskable source, drives 16'hFFFA and loads mask 2'b11.
- R7: A trap_stb pulse is taken at the next edge, with or without instr_end and regardless of the mask. It beats TLI and the maskable sources, drives 16'hFFFC and loads mask 2'b11.
- R8: An rst_req pulse beats everything, including IRET. It drives 16'hFFFE, loads mask 2'b11 and empties the mask stack.
- R9: Every take except a reset pushes cur_mask. When the stack holds an entry, iret_stb pops it and drives it on mask_new with mask_load, with no take in that cycle.
- R10: A take while the stack already holds 4 entries still happens. The stack stays unchanged and stk_err pulses together with irq_take.
- R11: An IRET with an empty stack pulses stk_err and does not pulse mask_load.
- R12: After reset, irq_take, mask_load and stk_err are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_SRC | Maskable request levels, one per source |
| tli_req | input | 1 | Top-level non-maskable request level |
| trap_stb | input | 1 | TRAP instruction strobe |
| rst_req | input | 1 | Reset-event strobe |
| iret_stb | input | 1 | IRET instruction strobe |
| instr_end | input | 1 | Instruction boundary strobe |
| cur_mask | input | 2 | CPU's current mask bits |
| reg_we | input | 1 | Priority register write enable |
| reg_addr | input | REG_AW | Priority register select |
| reg_wdata | input | 8 | Priority register write data |
| irq_take | output | 1 | One-cycle take pulse |
| irq_vec | output | 16 | Vector address of the taken event |
| mask_load | output | 1 | CPU must load mask_new |
| mask_new | output | 2 | Mask value to load |
| stk_err | output | 1 | Stack overflow or underflow pulse |

## Verification
The hardest case to reach is a full mask stack. There are only three usable levels, so nesting maskable sources alone can never push a fifth entry. The stimulus therefore chains TRAP strobes, which push no matter what the mask is. After four nested traps, a fifth trap has to be taken and also raise the error. A reset request, sent in the same cycle as an IRET, then must empty the stack. This is shown by the next IRET underflowing. Pending behaviour is reached by keeping a request asserted across an IRET that lowers the mask.

// File: rtl/nic_pkg.sv
package nic_pkg;
   typedef logic [1:0] mask_t;

   localparam mask_t MASK_L0 = 2'b10;
   localparam mask_t MASK_L1 = 2'b01;
   localparam mask_t MASK_L2 = 2'b00;
   localparam mask_t MASK_L3 = 2'b11;

   // maps the non-binary mask code onto an ordered rank 0..3
   function automatic logic [1:0] lvl_rank(input mask_t m);
      case (m)
         MASK_L0: return 2'd0;
         MASK_L1: return 2'd1;
         MASK_L2: return 2'd2;
         default: return 2'd3;
      endcase
   endfunction
endpackage

// File: rtl/nic_prio_regs.sv
module nic_prio_regs
   import nic_pkg::*;
#(
   parameter int NUM_SRC = 13,
   parameter int DATA_W  = 8,
   parameter int REG_AW  = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [REG_AW-1:0]         addr,
   input  logic [DATA_W-1:0]         wdata,
   output logic [NUM_SRC-1:0][1:0]   prio
);
   localparam int FPR     = DATA_W / 2;
   localparam int NUM_REG = (NUM_SRC + FPR - 1) / FPR;

   if (DATA_W % 2 != 0) begin : g_bad_dw
      $error("nic_prio_regs: DATA_W must be even");
   end
   if ((1 << REG_AW) < NUM_REG) begin : g_bad_aw
      $error("nic_prio_regs: REG_AW too narrow for the field count");
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_fld
      localparam int RIDX = i / FPR;
      localparam int LSB  = 2 * (i % FPR);
      mask_t fld;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            fld <= MASK_L3;
         else if (we && addr == REG_AW'(RIDX))
            fld <= wdata[LSB +: 2];
      end

      assign prio[i] = fld;

      // R2
      fld_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (we && addr == REG_AW'(RIDX)) |=> prio[i] == $past(wdata[LSB +: 2]));
   end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
   import nic_pkg::*;
#(
   parameter int NUM_SRC = 13,
   parameter int IDX_W   = 4
) (
   input  logic [NUM_SRC-1:0]        req,
   input  logic [NUM_SRC-1:0][1:0]   prio,
   input  mask_t                     cur_mask,
   output logic                      any,
   output logic [IDX_W-1:0]          idx,
   output mask_t                     win_mask
);
   logic [NUM_SRC-1:0] elig;
   logic [1:0]         best;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
      assign elig[i] = req[i] && (prio[i] != MASK_L3) &&
                       (lvl_rank(prio[i]) > lvl_rank(cur_mask));
   end

   // ascending scan with >= lets the higher index win a level tie
   always_comb begin
      any      = 1'b0;
      idx      = '0;
      best     = 2'd0;
      win_mask = MASK_L3;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (elig[i] && (!any || lvl_rank(prio[i]) >= best)) begin
            any      = 1'b1;
            best     = lvl_rank(prio[i]);
            idx      = IDX_W'(i);
            win_mask = prio[i];
         end
      end
   end
endmodule

// File: rtl/nic_mask_stack.sv
module nic_mask_stack
   import nic_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   clr,
   input  logic   push,
   input  logic   pop,
   input  mask_t  din,
   output mask_t  top,
   output logic   empty,
   output logic   err
);
   localparam int PW = $clog2(DEPTH + 1);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("nic_mask_stack: DEPTH must be at least 2");
   end

   mask_t [DEPTH-1:0] mem;
   logic  [PW-1:0]    cnt;
   logic  [PW-1:0]    cnt_m1;
   logic              full;

   assign full   = (cnt == PW'(DEPTH));
   assign empty  = (cnt == '0);
   assign cnt_m1 = cnt - 1'b1;
   assign top    = mem[cnt_m1[IW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         err <= 1'b0;
         mem <= '0;
      end else begin
         err <= 1'b0;
         if (clr) begin
            cnt <= '0;
         end else if (pop) begin
            if (empty) err <= 1'b1;
            else       cnt <= cnt_m1;
         end else if (push) begin
            if (full) begin
               err <= 1'b1;
            end else begin
               mem[cnt[IW-1:0]] <= din;
               cnt              <= cnt + 1'b1;
            end
         end
      end
   end

   // R10
   stk_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= PW'(DEPTH));

   // R10
   stk_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !clr && full) |=> err && $stable(cnt));

   // R11
   stk_empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !clr && empty) |=> err && cnt == '0);
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nic_pkg::*;
#(
   parameter int          NUM_SRC   = 13,
   parameter int          REG_AW    = 2,
   parameter int          STK_DEPTH = 4,
   parameter logic [15:0] VEC_BASE  = 16'hFFE0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_req,
   input  logic               tli_req,
   input  logic               trap_stb,
   input  logic               rst_req,
   input  logic               iret_stb,
   input  logic               instr_end,
   input  logic [1:0]         cur_mask,
   input  logic               reg_we,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic [7:0]         reg_wdata,
   output logic               irq_take,
   output logic [15:0]        irq_vec,
   output logic               mask_load,
   output logic [1:0]         mask_new,
   output logic               stk_err
);
   localparam int          IDX_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam logic [15:0] RST_VEC  = VEC_BASE + 16'd30;
   localparam logic [15:0] TRAP_VEC = VEC_BASE + 16'd28;
   localparam logic [15:0] TLI_VEC  = VEC_BASE + 16'd26;

   if (NUM_SRC < 1 || NUM_SRC > 13) begin : g_bad_src
      $error("nest_irq_ctrl: NUM_SRC must be 1..13 to leave room for fixed vectors");
   end

   logic [NUM_SRC-1:0][1:0] prio;
   logic                    win_any;
   logic [IDX_W-1:0]        win_idx;
   mask_t                   win_mask;
   mask_t                   stk_top;
   logic                    stk_empty;
   logic                    stk_push;
   logic                    stk_pop;
   logic                    bound_take;

   nic_prio_regs #(.NUM_SRC(NUM_SRC), .DATA_W(8), .REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
      .wdata(reg_wdata), .prio(prio));

   nic_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
      .req(irq_req), .prio(prio), .cur_mask(cur_mask),
      .any(win_any), .idx(win_idx), .win_mask(win_mask));

   assign bound_take = instr_end && (tli_req || win_any);
   assign stk_pop    = !rst_req && iret_stb;
   assign stk_push   = !rst_req && !iret_stb && (trap_stb || bound_take);

   nic_mask_stack #(.DEPTH(STK_DEPTH)) u_stk (
      .clk(clk), .rst_n(rst_n), .clr(rst_req), .push(stk_push),
      .pop(stk_pop), .din(cur_mask), .top(stk_top),
      .empty(stk_empty), .err(stk_err));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_take  <= 1'b0;
         irq_vec   <= '0;
         mask_load <= 1'b0;
         mask_new  <= MASK_L3;
      end else begin
         irq_take  <= 1'b0;
         mask_load <= 1'b0;
         if (rst_req) begin
            irq_take  <= 1'b1;
            irq_vec   <= RST_VEC;
            mask_load <= 1'b1;
            mask_new  <= MASK_L3;
         end else if (iret_stb) begin
            if (!stk_empty) begin
               mask_load <= 1'b1;
               mask_new  <= stk_top;
            end
         end else if (trap_stb) begin
            irq_take  <= 1'b1;
            irq_vec   <= TRAP_VEC;
            mask_load <= 1'b1;
            mask_new  <= MASK_L3;
         end else if (instr_end && tli_req) begin
            irq_take  <= 1'b1;
            irq_vec   <= TLI_VEC;
            mask_load <= 1'b1;
            mask_new  <= MASK_L3;
         end else if (instr_end && win_any) begin
            irq_take  <= 1'b1;
            irq_vec   <= VEC_BASE + 16'({win_idx, 1'b0});
            mask_load <= 1'b1;
            mask_new  <= win_mask;
         end
      end
   end

   // R8
   reset_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> irq_take && irq_vec == RST_VEC && mask_new == MASK_L3);

   // R7
   trap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_stb && !rst_req && !iret_stb) |=>
         irq_take && irq_vec == TRAP_VEC && mask_new == MASK_L3);

   // R3
   boundary_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && irq_vec <= TLI_VEC) |-> $past(instr_end));

   // R1
   level_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && irq_vec < TLI_VEC) |->
         lvl_rank(mask_new) > lvl_rank($past(cur_mask)));

   // R9
   iret_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iret_stb && !rst_req) |=> !irq_take);
endmodule

// File: tb/test_nest_irq_ctrl.sv
`timescale 1ns/1ps
module test_nest_irq_ctrl;
   localparam int NS = 13;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NS-1:0] irq_req;
   logic          tli_req, trap_stb, rst_req, iret_stb, instr_end;
   logic [1:0]    cur_mask;
   logic          reg_we;
   logic [1:0]    reg_addr;
   logic [7:0]    reg_wdata;
   logic          irq_take, mask_load, stk_err;
   logic [15:0]   irq_vec;
   logic [1:0]    mask_new;

   always #2.5 clk = ~clk;

   nest_irq_ctrl i_nest_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .tli_req(tli_req),
      .trap_stb(trap_stb), .rst_req(rst_req), .iret_stb(iret_stb),
      .instr_end(instr_end), .cur_mask(cur_mask), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_take(irq_take),
      .irq_vec(irq_vec), .mask_load(mask_load), .mask_new(mask_new),
      .stk_err(stk_err));

   typedef struct {
      bit        take;
      bit [15:0] vec;
      bit        load;
      bit [1:0]  mask;
      bit        err;
      string     tag;
   } exp_t;

   exp_t     sbq[$];
   int       errors = 0;
   int       checks = 0;
   bit       done = 0;
   bit [1:0] cpu_mask = 2'b10;
   bit [1:0] mprio[NS];
   bit [1:0] mstk[4];
   int       msp = 0;

   function automatic int rank(input bit [1:0] m);
      case (m)
         2'b10: return 0;
         2'b01: return 1;
         2'b00: return 2;
         default: return 3;
      endcase
   endfunction

   // driver: applies one cycle of stimulus and queues the expected outputs
   task automatic step(input bit [NS-1:0] rq, input bit tl, input bit ie,
                       input bit ir, input bit tr, input bit rr, input bit we_i,
                       input bit [1:0] ad, input bit [7:0] wd, input string tag);
      exp_t e;
      int   best;
      int   win;
      e.take = 0; e.vec = '0; e.load = 0; e.mask = '0; e.err = 0; e.tag = tag;
      irq_req = rq; tli_req = tl; instr_end = ie; iret_stb = ir;
      trap_stb = tr; rst_req = rr; reg_we = we_i; reg_addr = ad;
      reg_wdata = wd; cur_mask = cpu_mask;
      win = -1; best = -1;
      for (int i = 0; i < NS; i++) begin
         if (rq[i] && mprio[i] != 2'b11 && rank(mprio[i]) > rank(cpu_mask) &&
             rank(mprio[i]) >= best) begin
            best = rank(mprio[i]);
            win  = i;
         end
      end
      if (rr) begin
         e.take = 1; e.vec = 16'hFFFE; e.load = 1; e.mask = 2'b11; msp = 0;
      end else if (ir) begin
         if (msp > 0) begin
            msp = msp - 1; e.load = 1; e.mask = mstk[msp];
         end else begin
            e.err = 1;
         end
      end else if (tr || (ie && (tl || win >= 0))) begin
         e.take = 1; e.load = 1; e.mask = 2'b11;
         if (tr)      e.vec = 16'hFFFC;
         else if (tl) e.vec = 16'hFFFA;
         else begin
            e.vec  = 16'hFFE0 + 16'(2 * win);
            e.mask = mprio[win];
         end
         if (msp == 4) e.err = 1;
         else begin
            mstk[msp] = cpu_mask; msp = msp + 1;
         end
      end
      if (we_i)
         for (int j = 0; j < 4; j++)
            if (4 * ad + j < NS) mprio[4 * ad + j] = wd[2 * j +: 2];
      if (e.load) cpu_mask = e.mask;
      sbq.push_back(e);
      @(negedge clk);
   endtask

   task automatic idle(input string t);
      step('0, 0, 0, 0, 0, 0, 0, 2'd0, 8'h00, t);
   endtask
   task automatic wr(input bit [1:0] a, input bit [7:0] d, input string t);
      step('0, 0, 0, 0, 0, 0, 1, a, d, t);
   endtask
   task automatic req(input bit [NS-1:0] r, input bit ie, input string t);
      step(r, 0, ie, 0, 0, 0, 0, 2'd0, 8'h00, t);
   endtask
   task automatic iret(input string t);
      step('0, 0, 0, 1, 0, 0, 0, 2'd0, 8'h00, t);
   endtask
   task automatic trap(input string t);
      step('0, 0, 0, 0, 1, 0, 0, 2'd0, 8'h00, t);
   endtask

   // monitor: pops one expected item per cycle, 1 ns after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (irq_take !== e.take || (e.take && irq_vec !== e.vec) ||
                mask_load !== e.load || (e.load && mask_new !== e.mask) ||
                stk_err !== e.err) begin
               errors++;
               $display("FAIL %s: take=%0b vec=%h load=%0b mask=%b err=%0b expected take=%0b vec=%h load=%0b mask=%b err=%0b",
                        e.tag, irq_take, irq_vec, mask_load, mask_new, stk_err,
                        e.take, e.vec, e.load, e.mask, e.err);
            end
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NS; i++) mprio[i] = 2'b11;
      rst_n = 0; irq_req = '0; tli_req = 0; trap_stb = 0; rst_req = 0;
      iret_stb = 0; instr_end = 0; cur_mask = 2'b10; reg_we = 0;
      reg_addr = '0; reg_wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      checks++;
      if (irq_take !== 1'b0 || mask_load !== 1'b0 || stk_err !== 1'b0) begin
         errors++;
         $display("FAIL R12: take=%0b load=%0b err=%0b expected 0 0 0",
                  irq_take, mask_load, stk_err);
      end

      req(13'h001, 1, "R2 reset field disables source");
      wr(2'd0, 8'hC7, "R2 write reg0");
      wr(2'd1, 8'hF3, "R2 write reg1");
      req(13'h002, 0, "R3 no boundary no take");
      req(13'h002, 1, "R4 take src1 vector and mask");
      req(13'h002, 1, "R1 equal level not taken");
      req(13'h006, 1, "R5 higher level wins nest");
      iret("R9 restore level1");
      req(13'h002, 1, "R1 still pending at equal level");
      iret("R9 restore level0");
      req(13'h002, 1, "R1 pending taken after drop");
      iret("R9 restore after retake");
      iret("R11 underflow");
      wr(2'd0, 8'h07, "R2 raise src3");
      req(13'h028, 1, "R5 tie higher index wins");
      iret("R9 restore after tie");
      cpu_mask = 2'b11;
      step(13'h020, 1, 1, 0, 0, 0, 0, 2'd0, 8'h00, "R6 TLI past mask 3");
      iret("R9 restore after TLI");
      trap("R7 trap at mask 3");
      trap("R7 nested trap 2");
      trap("R7 nested trap 3");
      trap("R7 nested trap 4");
      trap("R10 overflow trap");
      step('0, 0, 0, 1, 0, 1, 0, 2'd0, 8'h00, "R8 reset beats iret");
      iret("R8 stack emptied");
      cpu_mask = 2'b10;
      step(13'h020, 1, 1, 0, 1, 0, 0, 2'd0, 8'h00, "R7 trap beats TLI and source");
      iret("R9 restore after trap");
      idle("R12 idle quiet");
      idle("R12 idle quiet 2");
      @(posedge clk);
      #2;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule